// File: doc/BRIEF.md
# Banked CPU Address Decoder

This block sits beside an 8-bit CPU on a game board and turns each bus cycle into a chip select. In a memory cycle it picks one of five regions: program ROM, palette RAM, attribute RAM, video RAM or work RAM. It also produces the 19-bit physical address for a 512 KiB program ROM. The low half of the CPU space is a fixed ROM view. The top quarter is a 16 KiB window whose placement inside the ROM comes from a bank register.

Bank numbers do not map linearly. Nine bank numbers each select a scattered 16 KiB page of the ROM. A bank number above the last valid one is treated as bank 0. In an I/O cycle only the low eight address bits are decoded. I/O writes load the bank register, a video RAM page bit and a display-disable flag. I/O reads return one of five 8-bit input lanes (system, player 1, player 2, switch bank 1, switch bank 2). The RAM arrays and the ROM contents sit outside the block.

Top module: `cpu_region_decoder`

## Requirements
- R1: In a memory cycle with a read or write strobe, exactly one select is high: `sel_rom` for 0x0000–0x7FFF and 0xC000–0xFFFF, `sel_pal` for 0x8000–0x87FF, `sel_attr` for 0x8800–0x8FFF, `sel_vram` for 0x9000–0x9FFF, and `sel_work` for 0xA000–0xBFFF.
- R2: With neither strobe high, or during an I/O cycle (`cpu_io`=1), all five selects are low.
- R3: For CPU addresses 0x0000–0x7FFF, `rom_addr` equals the CPU address with bits 18:15 zero.
- R4: For CPU addresses 0xC000–0xFFFF, `rom_addr` equals the base of the current bank plus CPU address bits 13:0. The bases for banks 0 to 8 are, in bank order, 0x28000, 0x14000, 0x1C000, 0x54000, 0x48000, 0x3C000, 0x18000, 0x4C000 and 0x50000.
- R5: An I/O write to port 0x12 loads the bank register from the data bus on the next clock edge. A value greater than 8 loads bank 0 instead.
- R6: After reset, the bank is 0, `vram_page` is 0 and `disp_off` is 0.
- R7: An I/O write to port 0x17 sets `vram_page` to data bit 0 at the next clock edge.
- R8: An I/O write to port 0x07 sets `disp_off` to data bit 0 at the next clock edge.
- R9: I/O port decoding uses only CPU address bits 7:0. Bits 15:8 have no effect on an I/O access.
- R10: During an I/O read of port 0x10+i (i = 0..4), `io_rdata` equals input lane i, taken from `in_lanes[8i+7:8i]`. For any other port, or when no I/O read is in progress, `io_rdata` is 0.
- R11: Memory writes, and I/O writes to ports other than 0x07, 0x12 and 0x17, leave the bank, `vram_page` and `disp_off` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high |
| cpu_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| in_lanes | input | 40 | Five 8-bit input lanes, lane 0 in the low byte |
| sel_rom | output | 1 | Program ROM select |
| sel_pal | output | 1 | Palette RAM select |
| sel_attr | output | 1 | Attribute RAM select |
| sel_vram | output | 1 | Video RAM select |
| sel_work | output | 1 | Work RAM select |
| rom_addr | output | 19 | Physical ROM address |
| vram_page | output | 1 | Video RAM page |
| disp_off | output | 1 | Display-disable flag |
| io_rdata | output | 8 | I/O read data |

## Verification
The memory map is tried at the first and last address of every region. These probes separate off-by-one region boundaries and show that the two ROM views are told apart by address bits 15:14. Each of the nine banks is written and then probed at the bottom and top of the window, which catches both a swapped table entry and a broken offset concatenation. Bank values of 9 and 0xFF are checked for the fallback to bank 0. Port accesses are repeated with different upper address bytes, and writes go to neighbouring ports to confirm that the registers do not move.

// File: rtl/crd_pkg.sv
package crd_pkg;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_ROM_FIX,
    RGN_ROM_WIN,
    RGN_PAL,
    RGN_ATTR,
    RGN_VRAM,
    RGN_WORK
  } region_e;

  localparam int NUM_BANKS = 9;
  localparam int IDX_W     = 4;
  localparam int PAGE_W    = 5;

  // 16 KiB page number of each bank base (base >> 14)
  function automatic logic [PAGE_W-1:0] bank_page(input logic [IDX_W-1:0] idx);
    logic [PAGE_W-1:0] pg;
    case (idx)
      4'd0:    pg = 5'h0A;
      4'd1:    pg = 5'h05;
      4'd2:    pg = 5'h07;
      4'd3:    pg = 5'h15;
      4'd4:    pg = 5'h12;
      4'd5:    pg = 5'h0F;
      4'd6:    pg = 5'h06;
      4'd7:    pg = 5'h13;
      4'd8:    pg = 5'h14;
      default: pg = 5'h0A;
    endcase
    return pg;
  endfunction

endpackage

// File: rtl/crd_mem_decode.sv
module crd_mem_decode
  import crd_pkg::*;
(
  input  logic [4:0] addr_hi,
  input  logic       cpu_io,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  output region_e    region
);

  always_comb begin
    region = RGN_NONE;
    if (!cpu_io && (cpu_rd || cpu_wr)) begin
      casez (addr_hi)
        5'b0????: region = RGN_ROM_FIX;
        5'b10000: region = RGN_PAL;
        5'b10001: region = RGN_ATTR;
        5'b1001?: region = RGN_VRAM;
        5'b101??: region = RGN_WORK;
        default:  region = RGN_ROM_WIN;
      endcase
    end
  end

endmodule

// File: rtl/crd_bank_reg.sv
module crd_bank_reg
  import crd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  bank_idx,
  output logic [PAGE_W-1:0] bank_pg
);

  localparam logic [DATA_W-1:0] LAST_BANK = DATA_W'(NUM_BANKS - 1);

  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = bank_idx;
    if (load_en) begin
      if (wdata > LAST_BANK) idx_d = '0;
      else                   idx_d = wdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_idx <= '0;
    else if (load_en) bank_idx <= idx_d;
  end

  assign bank_pg = bank_page(bank_idx);

endmodule

// File: rtl/crd_io_block.sv
module crd_io_block #(
  parameter int              DATA_W     = 8,
  parameter int              IO_AW      = 8,
  parameter int              NUM_LANES  = 5,
  parameter logic [IO_AW-1:0] PORT_BANK  = 8'h12,
  parameter logic [IO_AW-1:0] PORT_PAGE  = 8'h17,
  parameter logic [IO_AW-1:0] PORT_BLANK = 8'h07,
  parameter logic [IO_AW-1:0] PORT_LANE0 = 8'h10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IO_AW-1:0]            port,
  input  logic                        cpu_io,
  input  logic                        cpu_rd,
  input  logic                        cpu_wr,
  input  logic                        wbit,
  input  logic [NUM_LANES*DATA_W-1:0] lanes,
  output logic                        bank_we,
  output logic                        vram_page,
  output logic                        disp_off,
  output logic [DATA_W-1:0]           rdata
);

  logic io_wr, io_rd, page_we, blank_we;
  logic page_d, blank_d;
  logic [NUM_LANES-1:0] lane_hit;

  assign io_wr    = cpu_io && cpu_wr;
  assign io_rd    = cpu_io && cpu_rd;
  assign bank_we  = io_wr && (port == PORT_BANK);
  assign page_we  = io_wr && (port == PORT_PAGE);
  assign blank_we = io_wr && (port == PORT_BLANK);

  always_comb begin
    page_d  = page_we  ? wbit : vram_page;
    blank_d = blank_we ? wbit : disp_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vram_page <= 1'b0;
      disp_off  <= 1'b0;
    end else begin
      if (page_we)  vram_page <= page_d;
      if (blank_we) disp_off  <= blank_d;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LANES; gi++) begin : g_lane
      assign lane_hit[gi] = io_rd && (port == PORT_LANE0 + IO_AW'(gi));
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (lane_hit[i]) rdata = rdata | lanes[i*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/cpu_region_decoder.sv
module cpu_region_decoder
  import crd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int ROM_AW    = 19,
  parameter int IO_AW     = 8,
  parameter int NUM_LANES = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [DATA_W-1:0]           cpu_wdata,
  input  logic                        cpu_rd,
  input  logic                        cpu_wr,
  input  logic                        cpu_io,
  input  logic [NUM_LANES*DATA_W-1:0] in_lanes,
  output logic                        sel_rom,
  output logic                        sel_pal,
  output logic                        sel_attr,
  output logic                        sel_vram,
  output logic                        sel_work,
  output logic [ROM_AW-1:0]           rom_addr,
  output logic                        vram_page,
  output logic                        disp_off,
  output logic [DATA_W-1:0]           io_rdata
);

  localparam int WIN_AW = 14;
  localparam int FIX_AW = ADDR_W - 1;

  region_e           region;
  logic              bank_we;
  logic [IDX_W-1:0]  bank_idx;
  logic [PAGE_W-1:0] bank_pg;

  crd_mem_decode u_dec (
    .addr_hi (cpu_addr[ADDR_W-1 -: 5]),
    .cpu_io  (cpu_io),
    .cpu_rd  (cpu_rd),
    .cpu_wr  (cpu_wr),
    .region  (region)
  );

  crd_io_block #(
    .DATA_W    (DATA_W),
    .IO_AW     (IO_AW),
    .NUM_LANES (NUM_LANES)
  ) u_io (
    .clk       (clk),
    .rst_n     (rst_n),
    .port      (cpu_addr[IO_AW-1:0]),
    .cpu_io    (cpu_io),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .wbit      (cpu_wdata[0]),
    .lanes     (in_lanes),
    .bank_we   (bank_we),
    .vram_page (vram_page),
    .disp_off  (disp_off),
    .rdata     (io_rdata)
  );

  crd_bank_reg #(.DATA_W(DATA_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (bank_we),
    .wdata    (cpu_wdata),
    .bank_idx (bank_idx),
    .bank_pg  (bank_pg)
  );

  assign sel_rom  = (region == RGN_ROM_FIX) || (region == RGN_ROM_WIN);
  assign sel_pal  = (region == RGN_PAL);
  assign sel_attr = (region == RGN_ATTR);
  assign sel_vram = (region == RGN_VRAM);
  assign sel_work = (region == RGN_WORK);

  // Top quarter of CPU space: page concatenated with window offset
  always_comb begin
    if (cpu_addr[ADDR_W-1 -: 2] == 2'b11)
      rom_addr = {bank_pg, cpu_addr[WIN_AW-1:0]};
    else
      rom_addr = {{(ROM_AW-FIX_AW){1'b0}}, cpu_addr[FIX_AW-1:0]};
  end

endmodule

// File: rtl/cpu_region_decoder_chk.sv
module cpu_region_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic        cpu_io,
  input logic        sel_rom,
  input logic        sel_pal,
  input logic        sel_attr,
  input logic        sel_vram,
  input logic        sel_work,
  input logic [18:0] rom_addr,
  input logic        vram_page,
  input logic        disp_off,
  input logic [3:0]  bank_idx
);

  logic [4:0] sels;
  assign sels = {sel_rom, sel_pal, sel_attr, sel_vram, sel_work};

  p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_io && (cpu_rd || cpu_wr)) |-> ($countones(sels) == 1));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_io || !(cpu_rd || cpu_wr)) |-> (sels == 5'b0));

  p_fixed_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rom && !cpu_addr[15]) |-> (rom_addr == {4'b0, cpu_addr[14:0]}));

  p_window_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rom && cpu_addr[15]) |-> (rom_addr[13:0] == cpu_addr[13:0]));

  p_bank_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_io && cpu_wr && cpu_addr[7:0] == 8'h12 && cpu_wdata > 8'd8) |=> (bank_idx == 4'd0));

  p_page_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_io && cpu_wr && cpu_addr[7:0] == 8'h17) |=> (vram_page == $past(cpu_wdata[0])));

  p_blank_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_io && cpu_wr && cpu_addr[7:0] == 8'h07) |=> (disp_off == $past(cpu_wdata[0])));

  p_regs_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_io && cpu_wr) |=> ($stable(vram_page) && $stable(disp_off) && $stable(bank_idx)));

endmodule

bind cpu_region_decoder cpu_region_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_io    (cpu_io),
  .sel_rom   (sel_rom),
  .sel_pal   (sel_pal),
  .sel_attr  (sel_attr),
  .sel_vram  (sel_vram),
  .sel_work  (sel_work),
  .rom_addr  (rom_addr),
  .vram_page (vram_page),
  .disp_off  (disp_off),
  .bank_idx  (bank_idx)
);

// File: tb/cpu_region_decoder_test.sv
module cpu_region_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_io = 1'b0;
  logic [39:0] in_lanes = 40'h5A_C3_3C_96_E1;
  logic        sel_rom, sel_pal, sel_attr, sel_vram, sel_work;
  logic [18:0] rom_addr;
  logic        vram_page, disp_off;
  logic [7:0]  io_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  cpu_region_decoder uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_io(cpu_io), .in_lanes(in_lanes),
    .sel_rom(sel_rom), .sel_pal(sel_pal), .sel_attr(sel_attr),
    .sel_vram(sel_vram), .sel_work(sel_work), .rom_addr(rom_addr),
    .vram_page(vram_page), .disp_off(disp_off), .io_rdata(io_rdata)
  );

  // {addr[16], rd, wr, exp_sel{rom,pal,attr,vram,work}[5], exp_rom[19]} = 42 bits
  localparam int NV = 13;
  localparam logic [41:0] VEC [NV] = '{
    {16'h0000, 2'b10, 5'b10000, 19'h00000},
    {16'h7FFF, 2'b10, 5'b10000, 19'h07FFF},
    {16'h8000, 2'b01, 5'b01000, 19'h00000},
    {16'h87FF, 2'b10, 5'b01000, 19'h00000},
    {16'h8800, 2'b01, 5'b00100, 19'h00000},
    {16'h8FFF, 2'b10, 5'b00100, 19'h00000},
    {16'h9000, 2'b10, 5'b00010, 19'h00000},
    {16'h9FFF, 2'b01, 5'b00010, 19'h00000},
    {16'hA000, 2'b10, 5'b00001, 19'h00000},
    {16'hBFFF, 2'b01, 5'b00001, 19'h00000},
    {16'hC000, 2'b10, 5'b10000, 19'h28000},
    {16'hFFFF, 2'b10, 5'b10000, 19'h2BFFF},
    {16'h1234, 2'b00, 5'b00000, 19'h00000}
  };

  localparam logic [18:0] BASES [9] = '{
    19'h28000, 19'h14000, 19'h1C000, 19'h54000, 19'h48000,
    19'h3C000, 19'h18000, 19'h4C000, 19'h50000
  };

  function automatic logic [4:0] sels();
    return {sel_rom, sel_pal, sel_attr, sel_vram, sel_work};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mem_probe(input logic [15:0] a, input logic rd, input logic wr,
                           output logic [4:0] s, output logic [18:0] ra);
    @(negedge clk);
    cpu_io = 1'b0; cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
    #1;
    s = sels(); ra = rom_addr;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_io = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_io = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic [4:0] s);
    @(negedge clk);
    cpu_io = 1'b1; cpu_addr = a; cpu_rd = 1'b1;
    #1;
    d = io_rdata; s = sels();
    @(negedge clk);
    cpu_rd = 1'b0; cpu_io = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [4:0]  s;
    logic [18:0] ra;
    logic [7:0]  d;

    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6 page", {31'b0, vram_page}, 0);
    check("R6 disp", {31'b0, disp_off}, 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4: memory map table (bank 0 after reset)
    for (int i = 0; i < NV; i++) begin
      mem_probe(VEC[i][41:26], VEC[i][25], VEC[i][24], s, ra);
      check("R1/R2 select", {27'b0, s}, {27'b0, VEC[i][23:19]});
      if (VEC[i][23]) check("R3/R4 rom_addr", {13'b0, ra}, {13'b0, VEC[i][18:0]});
    end

    // R2: I/O cycle raises no memory select
    io_read(16'h8010, d, s);
    check("R2 io no select", {27'b0, s}, 0);

    // R4 R5 R9: every bank, upper address byte varied
    for (int b = 0; b < 9; b++) begin
      io_write({8'(b * 17), 8'h12}, 8'(b));
      mem_probe(16'hC000, 1'b1, 1'b0, s, ra);
      check("R4 bank base", {13'b0, ra}, {13'b0, BASES[b]});
      mem_probe(16'hE5A7, 1'b1, 1'b0, s, ra);
      check("R4 bank offset", {13'b0, ra}, {13'b0, BASES[b] + 19'h025A7});
    end

    // R5: out of range falls back to bank 0
    io_write(16'h0012, 8'd9);
    mem_probe(16'hC001, 1'b1, 1'b0, s, ra);
    check("R5 clamp 9", {13'b0, ra}, {13'b0, 19'h28001});
    io_write(16'h0012, 8'd3);
    io_write(16'hFF12, 8'hFF);
    mem_probe(16'hC001, 1'b1, 1'b0, s, ra);
    check("R5 clamp FF", {13'b0, ra}, {13'b0, 19'h28001});

    // R7 R8 R9
    io_write(16'h3317, 8'h01);
    check("R7 page set", {31'b0, vram_page}, 1);
    io_write(16'h0007, 8'hFF);
    check("R8 disp set", {31'b0, disp_off}, 1);
    io_write(16'hA907, 8'hFE);
    check("R8/R9 disp clear", {31'b0, disp_off}, 0);

    // R11: neighbouring ports and memory writes leave state
    io_write(16'h0016, 8'h00);
    io_write(16'h0018, 8'h00);
    io_write(16'h0013, 8'h05);
    io_write(16'h0006, 8'h01);
    mem_probe(16'h9017, 1'b0, 1'b1, s, ra);
    check("R11 page held", {31'b0, vram_page}, 1);
    check("R11 disp held", {31'b0, disp_off}, 0);
    mem_probe(16'hC000, 1'b1, 1'b0, s, ra);
    check("R11 bank held", {13'b0, ra}, {13'b0, 19'h28000});

    // R10 R9: input lanes
    for (int p = 0; p < 5; p++) begin
      io_read({8'(p * 40 + 1), 8'(16 + p)}, d, s);
      check("R10 lane", {24'b0, d}, {24'b0, in_lanes[p*8 +: 8]});
    end
    io_read(16'h0015, d, s);
    check("R10 unmapped port", {24'b0, d}, 0);
    io_read(16'h000F, d, s);
    check("R10 below range", {24'b0, d}, 0);

    // R6: reset mid-run returns to bank 0, page 0, display on
    io_write(16'h0012, 8'd7);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R6 reset page", {31'b0, vram_page}, 0);
    rst_n = 1'b1;
    mem_probe(16'hC000, 1'b1, 1'b0, s, ra);
    check("R6 reset bank", {13'b0, ra}, {13'b0, 19'h28000});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule